// File: doc/BRIEF.md
# Sleep and Wake Mode Controller

This block decides whether a motor-driver chip is awake or asleep. It runs from a fast system clock but advances all of its filters only on a slow enable tick, nominally 100 kHz, so one tick is 10 µs. It watches three levels. The first is a battery-level enable line that can wake the chip. The second is a keep-alive line driven by the host, which can only hold the chip awake. The third is the received level of the LIN bus, where low means dominant. It also watches a pulse that reports the first valid watchdog trigger.

The chip leaves reset awake. It falls asleep only when the keep-alive line has been validly high and then stays validly low. It wakes on a debounced high on the wake enable, or on a bus-low level that is held without a break through the whole filter window. The regulator enable, the battery-measurement switch enable and a sleep flag that shuts down the watchdog all follow the mode. A diagnostic output reports whether the last wake came from the bus. It holds that report until the first valid watchdog trigger.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: When reset is released, the block is awake: `sleepOut`=0, `regEnOut`=1, `battSwEnOut`=1 and `wakeSrcDiagOut`=0.
- R2: While awake, the block goes to sleep once `hostHoldIn` has been sampled high on at least `HOLD_DEB_TICKS` (default 2) consecutive ticks and has then been sampled low on `SLEEP_LOW_TICKS` (default 2) consecutive ticks.
- R3: If `hostHoldIn` goes low without first having been high for the debounce time, the block stays awake.
- R4: While asleep, `regEnOut` and `battSwEnOut` are 0. While awake, both are 1. `sleepOut` is always the inverse of `regEnOut`.
- R5: While asleep, `hvWakeIn` sampled high on `HV_DEB_TICKS` (default 2) consecutive ticks wakes the block. A high on a single tick does not wake it.
- R6: While asleep, `busRxIn` sampled low on `BUS_WAKE_TICKS` (default 7) consecutive ticks wakes the block. A tick that samples it high restarts the count.
- R7: While asleep, `hostHoldIn` has no effect, and a high level on it does not wake the block.
- R8: After a wake, `wakeSrcDiagOut` is 1 if the bus caused the wake and 0 if the wake enable caused it. It reads 0 again after a `wdTrigOk` pulse while awake.
- R9: After a wake, the block stays awake with `hostHoldIn` and `hvWakeIn` both low, for as long as no new valid-high-then-low sequence occurs on `hostHoldIn`.
- R10: If both wake filters complete in the same cycle, the wake is recorded as coming from the wake enable (`wakeSrcDiagOut`=0).
- R11: Filters advance only in cycles where `tick`=1. A level that is present only between ticks is never counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | One-cycle enable pulse at the 100 kHz filter rate |
| hvWakeIn | input | 1 | Battery-level wake enable, active high |
| hostHoldIn | input | 1 | Host keep-alive level, active high |
| busRxIn | input | 1 | Received bus level, 0 = dominant |
| wdTrigOk | input | 1 | Pulse: a valid watchdog trigger was accepted |
| regEnOut | output | 1 | Supply regulator enable |
| battSwEnOut | output | 1 | Battery-measurement switch enable |
| sleepOut | output | 1 | 1 while asleep; turns the watchdog off |
| wakeSrcDiagOut | output | 1 | 1 = the last wake came from the bus, shown until the first trigger |

## Verification
If a filter counter is corrupted, the block wakes or sleeps at the wrong tick. The mode outputs show this one clock after the tick that should have completed the filter, or should not have. If the keep-alive arm flag is stuck, the block either never sleeps or sleeps after a short host pulse. If the wake-source or display flag is wrong, the diagnostic output shows it in the first cycle after the wake, or after the trigger pulse. The bench compares every output against its own model in every cycle, so each such fault appears within one cycle.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;

  typedef enum logic {
    MODE_ACTIVE = 1'b0,
    MODE_SLEEP  = 1'b1
  } pwr_mode_e;

  // control -> datapath
  typedef struct packed {
    logic busFiltEn;  // bus wake filter may run
    logic holdClr;    // hold-off keep-alive tracking
  } ctrl_strobe_t;

  // datapath -> control
  typedef struct packed {
    logic hvValid;
    logic busValid;
    logic sleepReq;
  } dp_status_t;

endpackage

// File: rtl/pwr_mode_satcnt.sv
module pwr_mode_satcnt #(
  parameter int LIMIT = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic advance,
  input  logic cond,
  input  logic clr,
  output logic hit
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LIM = CW'(LIMIT);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (clr) begin
      cnt <= '0;
    end else if (advance) begin
      if (!cond)           cnt <= '0;
      else if (cnt != LIM) cnt <= cnt + CW'(1);
    end
  end

  assign hit = (cnt == LIM);
endmodule

// File: rtl/pwr_mode_dp.sv
module pwr_mode_dp
  import pwr_mode_pkg::*;
#(
  parameter int HV_DEB_TICKS    = 2,
  parameter int BUS_WAKE_TICKS  = 7,
  parameter int HOLD_DEB_TICKS  = 2,
  parameter int SLEEP_LOW_TICKS = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         hvWakeIn,
  input  logic         hostHoldIn,
  input  logic         busRxIn,
  input  ctrl_strobe_t strobe,
  output dp_status_t   status
);
  localparam int NFILT = 4;
  localparam int LIMS [NFILT] = '{HV_DEB_TICKS, BUS_WAKE_TICKS,
                                  HOLD_DEB_TICKS, SLEEP_LOW_TICKS};

  logic [NFILT-1:0] fCond, fClr, fHit;
  logic holdArmed;

  // 0: wake enable high, 1: bus dominant, 2: keep-alive high, 3: keep-alive low
  assign fCond = {!hostHoldIn, hostHoldIn, !busRxIn, hvWakeIn};
  assign fClr  = {strobe.holdClr, strobe.holdClr, !strobe.busFiltEn, 1'b0};

  for (genvar g = 0; g < NFILT; g++) begin : g_filt
    pwr_mode_satcnt #(.LIMIT(LIMS[g])) cnt_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .advance(tick),
      .cond   (fCond[g]),
      .clr    (fClr[g]),
      .hit    (fHit[g])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               holdArmed <= 1'b0;
    else if (strobe.holdClr)  holdArmed <= 1'b0;
    else if (fHit[2])         holdArmed <= 1'b1;
  end

  assign status.hvValid  = fHit[0];
  assign status.busValid = fHit[1];
  assign status.sleepReq = holdArmed & fHit[3];
endmodule

// File: rtl/pwr_mode_fsm.sv
module pwr_mode_fsm
  import pwr_mode_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wdTrigOk,
  input  dp_status_t   status,
  output ctrl_strobe_t strobe,
  output logic         regEnOut,
  output logic         battSwEnOut,
  output logic         sleepOut,
  output logic         wakeSrcDiagOut
);
  pwr_mode_e mode;
  logic srcIsBus;
  logic srcShow;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode     <= MODE_ACTIVE;
      srcIsBus <= 1'b0;
      srcShow  <= 1'b0;
    end else begin
      case (mode)
        MODE_ACTIVE: begin
          if (wdTrigOk)        srcShow <= 1'b0;
          if (status.sleepReq) mode    <= MODE_SLEEP;
        end
        MODE_SLEEP: begin
          if (status.hvValid) begin
            mode     <= MODE_ACTIVE;
            srcIsBus <= 1'b0;
            srcShow  <= 1'b1;
          end else if (status.busValid) begin
            mode     <= MODE_ACTIVE;
            srcIsBus <= 1'b1;
            srcShow  <= 1'b1;
          end
        end
        default: mode <= MODE_ACTIVE;
      endcase
    end
  end

  always_comb begin
    strobe.busFiltEn = (mode == MODE_SLEEP);
    strobe.holdClr   = (mode == MODE_SLEEP);
  end

  assign sleepOut       = (mode == MODE_SLEEP);
  assign regEnOut       = (mode == MODE_ACTIVE);
  assign battSwEnOut    = (mode == MODE_ACTIVE);
  assign wakeSrcDiagOut = srcShow & srcIsBus;
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pwr_mode_pkg::*;
#(
  parameter int HV_DEB_TICKS    = 2,
  parameter int BUS_WAKE_TICKS  = 7,
  parameter int HOLD_DEB_TICKS  = 2,
  parameter int SLEEP_LOW_TICKS = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic hvWakeIn,
  input  logic hostHoldIn,
  input  logic busRxIn,
  input  logic wdTrigOk,
  output logic regEnOut,
  output logic battSwEnOut,
  output logic sleepOut,
  output logic wakeSrcDiagOut
);
  ctrl_strobe_t strobe;
  dp_status_t   stat;

  pwr_mode_dp #(
    .HV_DEB_TICKS   (HV_DEB_TICKS),
    .BUS_WAKE_TICKS (BUS_WAKE_TICKS),
    .HOLD_DEB_TICKS (HOLD_DEB_TICKS),
    .SLEEP_LOW_TICKS(SLEEP_LOW_TICKS)
  ) dp_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .hvWakeIn  (hvWakeIn),
    .hostHoldIn(hostHoldIn),
    .busRxIn   (busRxIn),
    .strobe    (strobe),
    .status    (stat)
  );

  pwr_mode_fsm fsm_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .wdTrigOk      (wdTrigOk),
    .status        (stat),
    .strobe        (strobe),
    .regEnOut      (regEnOut),
    .battSwEnOut   (battSwEnOut),
    .sleepOut      (sleepOut),
    .wakeSrcDiagOut(wakeSrcDiagOut)
  );
endmodule

// File: rtl/pwr_mode_ctrl_chk.sv
module pwr_mode_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic wdTrigOk,
  input logic regEnOut,
  input logic battSwEnOut,
  input logic sleepOut,
  input logic wakeSrcDiagOut,
  input logic hvValid,
  input logic busValid,
  input logic sleepReq
);
  assert_rails_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (regEnOut != sleepOut) && (battSwEnOut == regEnOut));

  assert_sleep_entry_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sleepOut) |-> $past(sleepReq));

  assert_wake_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sleepOut) |-> $past(hvValid || busValid));

  assert_bus_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wakeSrcDiagOut) |-> ($fell(sleepOut) && $past(busValid) && !$past(hvValid)));

  assert_diag_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wdTrigOk && !sleepOut) |=> !wakeSrcDiagOut);
endmodule

bind pwr_mode_ctrl pwr_mode_ctrl_chk chk_i (
  .clk           (clk),
  .rst_n         (rst_n),
  .wdTrigOk      (wdTrigOk),
  .regEnOut      (regEnOut),
  .battSwEnOut   (battSwEnOut),
  .sleepOut      (sleepOut),
  .wakeSrcDiagOut(wakeSrcDiagOut),
  .hvValid       (stat.hvValid),
  .busValid      (stat.busValid),
  .sleepReq      (stat.sleepReq)
);

// File: tb/pwr_mode_ctrl_tb.sv
module pwr_mode_ctrl_tb_top;
  localparam int HV_N = 2, BUS_N = 7, HI_N = 2, LO_N = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic hvWakeIn = 1'b0, hostHoldIn = 1'b0, busRxIn = 1'b1, wdTrigOk = 1'b0;
  logic regEnOut, battSwEnOut, sleepOut, wakeSrcDiagOut;

  int nChecks = 0, nFail = 0;
  bit finished = 0;
  string phase = "R1";
  int divCnt = 0;

  always #2.5 clk = ~clk;

  pwr_mode_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .hvWakeIn(hvWakeIn),
    .hostHoldIn(hostHoldIn), .busRxIn(busRxIn), .wdTrigOk(wdTrigOk),
    .regEnOut(regEnOut), .battSwEnOut(battSwEnOut), .sleepOut(sleepOut),
    .wakeSrcDiagOut(wakeSrcDiagOut)
  );

  // tick every 5 clocks
  always @(posedge clk) begin
    divCnt <= (divCnt == 4) ? 0 : divCnt + 1;
    tick   <= (divCnt == 4);
  end

  // reference model built from the requirements
  int mHv, mBus, mHi, mLo;
  bit mArmed, mSleep, mSrc, mShow;
  bit oSleep, hvOk, busOk, reqOk, hiOk;

  function automatic int satStep(int c, bit cond, int lim);
    if (!cond) return 0;
    return (c == lim) ? c : c + 1;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      mHv = 0; mBus = 0; mHi = 0; mLo = 0;
      mArmed = 0; mSleep = 0; mSrc = 0; mShow = 0;
    end else begin
      oSleep = mSleep;
      hvOk   = (mHv == HV_N);
      busOk  = (mBus == BUS_N);
      reqOk  = mArmed && (mLo == LO_N);
      hiOk   = (mHi == HI_N);
      if (!oSleep) begin
        if (wdTrigOk) mShow = 0;
        if (reqOk) mSleep = 1;
      end else if (hvOk) begin
        mSleep = 0; mSrc = 0; mShow = 1;
      end else if (busOk) begin
        mSleep = 0; mSrc = 1; mShow = 1;
      end
      if (tick) mHv = satStep(mHv, hvWakeIn, HV_N);
      if (!oSleep) mBus = 0;
      else if (tick) mBus = satStep(mBus, !busRxIn, BUS_N);
      if (oSleep) begin
        mHi = 0; mLo = 0; mArmed = 0;
      end else begin
        if (hiOk) mArmed = 1;
        if (tick) begin
          mHi = satStep(mHi, hostHoldIn, HI_N);
          mLo = satStep(mLo, !hostHoldIn, LO_N);
        end
      end
    end
  end

  task automatic check(string tag, logic act, logic exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      check({phase, " sleepOut"}, sleepOut, mSleep);
      check("R4 regEnOut", regEnOut, !mSleep);
      check("R4 battSwEnOut", battSwEnOut, !mSleep);
      check("R8 wakeSrcDiagOut", wakeSrcDiagOut, mShow & mSrc);
    end
  end

  task automatic waitTicks(int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      while (!tick) @(posedge clk);
    end
    @(negedge clk);
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  task automatic goSleep();
    hostHoldIn = 1'b1; waitTicks(3);
    hostHoldIn = 1'b0; waitTicks(3);
    settle();
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: actual=hung expected=done");
    finishRun();
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 sleepOut", sleepOut, 1'b0);
    check("R1 regEnOut", regEnOut, 1'b1);
    check("R1 battSwEnOut", battSwEnOut, 1'b1);
    check("R1 wakeSrcDiagOut", wakeSrcDiagOut, 1'b0);

    phase = "R3";
    hostHoldIn = 1'b1; waitTicks(1);
    hostHoldIn = 1'b0; waitTicks(5); settle();
    check("R3 short host pulse keeps awake", sleepOut, 1'b0);

    phase = "R2";
    goSleep();
    check("R2 asleep after valid high then low", sleepOut, 1'b1);
    check("R4 regulator off in sleep", regEnOut, 1'b0);

    phase = "R7";
    hostHoldIn = 1'b1; waitTicks(5); settle();
    check("R7 host high does not wake", sleepOut, 1'b1);
    hostHoldIn = 1'b0; waitTicks(2);

    phase = "R5";
    hvWakeIn = 1'b1; waitTicks(1);
    hvWakeIn = 1'b0; waitTicks(3); settle();
    check("R5 single-tick enable ignored", sleepOut, 1'b1);
    hvWakeIn = 1'b1; waitTicks(2); settle();
    check("R5 debounced enable wakes", sleepOut, 1'b0);
    check("R8 enable wake flag", wakeSrcDiagOut, 1'b0);
    hvWakeIn = 1'b0;

    phase = "R9";
    waitTicks(10); settle();
    check("R9 awake with inputs low", sleepOut, 1'b0);

    phase = "R6";
    goSleep();
    busRxIn = 1'b0; waitTicks(5);
    busRxIn = 1'b1; waitTicks(1);
    busRxIn = 1'b0; waitTicks(5); settle();
    check("R6 broken bus low does not wake", sleepOut, 1'b1);
    waitTicks(3); settle();
    check("R6 bus low held wakes", sleepOut, 1'b0);
    check("R8 bus wake flag", wakeSrcDiagOut, 1'b1);
    busRxIn = 1'b1;
    waitTicks(4); settle();
    check("R9 awake after bus wake", sleepOut, 1'b0);

    phase = "R8";
    wdTrigOk = 1'b1; @(negedge clk); wdTrigOk = 1'b0; settle();
    check("R8 flag cleared by trigger", wakeSrcDiagOut, 1'b0);

    phase = "R10";
    goSleep();
    busRxIn = 1'b0; waitTicks(5);
    hvWakeIn = 1'b1; waitTicks(2); settle();
    check("R10 simultaneous wake awake", sleepOut, 1'b0);
    check("R10 simultaneous wake reports enable", wakeSrcDiagOut, 1'b0);
    busRxIn = 1'b1; hvWakeIn = 1'b0;

    phase = "R11";
    for (int t = 0; t < 800; t++) begin
      hostHoldIn = ($urandom % 3) != 0;
      hvWakeIn   = ($urandom % 10) == 0;
      busRxIn    = ($urandom % 4) == 0;
      wdTrigOk   = ($urandom % 6) == 0;
      @(negedge clk);
      wdTrigOk = 1'b0;
      if (($urandom % 2) == 0) begin
        // a glitch between ticks that the filters must not count (R11)
        @(posedge clk);
        if (!tick) begin
          @(negedge clk);
          if (!tick) begin hvWakeIn = 1'b1; @(negedge clk); hvWakeIn = 1'b0; end
        end
      end
      waitTicks(1 + ($urandom % 3));
    end
    settle();
    finishRun();
  end
endmodule